// File: doc/BRIEF.md
# Four-Backplane LCD Drive Sequencer

This block drives a passive LCD panel that multiplexes four backplanes at half bias. The panel has 32 segment lines and 4 common lines. Every common pin has its own output enable. When a common is not being driven, its enable drops and an external pair of equal resistors pulls that pin to half the supply. The segment lines only ever swing between ground and the supply. A frame is a fixed sequence of eight control periods. Each common gets two periods in turn, the first with the common low and the second with the common high, and the segment data is inverted in the second period so that no DC builds up across any segment.

Every control period starts with an active part and ends with a dead part. A contrast value sets where the active part ends. A mode pin picks how the lines are driven during the dead part. One rule pulls every line to ground, which lowers the RMS drive. The other rule holds the commons at the level they had and drives the segments to the opposite rail, which raises the RMS drive. A prescaler divides the clock into count steps, and the length of a period is given in those steps.

The 128-bit segment image enters through a valid/ready port. Ready is high only in the last clock cycle of a frame, and in the first enabled cycle before the first frame. A producer that holds valid is therefore kept waiting, for up to one frame, until the next frame boundary. The contrast, period length and dead-time mode are plain inputs. They are sampled in the same boundary cycle. Dropping the enable takes every line to ground and clears the bias enable.

Top module: `lcdq_seq`

## Requirements
- R1: While in reset or with `en` low, `bias_en` is 0, every `com_oe` bit is 1, every `com_out` bit is 0, `seg_out` is 0 and `frame_start` is 0.
- R2: After the first rising edge at which `en` is high, the block is in step 0 of control period 0. Each step lasts DIV clock cycles. A period has `period_len` steps, and a frame has 8 periods. Period k serves common k/2, with polarity k mod 2 (0 means the common is low, 1 means the common is high).
- R3: In the active part of a polarity-0 period for common c, `com_oe` is one-hot at bit c and `com_out` is 0. The other commons are released. `seg_out[s]` equals pattern bit c*32+s.
- R4: In the active part of a polarity-1 period for common c, `com_oe` is one-hot at bit c and `com_out[c]` is 1. `seg_out` is the bitwise inverse of the row used in R3.
- R5: Step t of a period is active when t < period_len − contrast. When the contrast is at or above the period length, the period has no active part.
- R6: With mode 0, every dead part drives all commons (`com_oe` all 1s) and `com_out` and `seg_out` are all 0.
- R7: With mode 1, a dead part in a polarity-0 period drives all commons low and all segments high. A dead part in a polarity-1 period drives all commons high and all segments low.
- R8: `pat_ready` is high exactly in the last cycle of each frame, and in the first enabled cycle. A pattern offered with `pat_valid` in that cycle is used from the following frame onward. Otherwise the held pattern is kept; its reset value is all zeros.
- R9: `contrast`, `period_len` and `mode` act only through the values sampled in the `pat_ready` cycle. A change in the middle of a frame takes effect at the next frame.
- R10: `frame_start` is a one-cycle pulse in the first cycle of period 0 of every frame.
- R11: A sampled `period_len` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Panel enable |
| mode | input | 1 | Dead-part rule: 0 lowers RMS, 1 raises RMS |
| period_len | input | CNT_W | Control period length in prescaled steps |
| contrast | input | CNT_W | Dead-part length in steps (0 = darkest) |
| pat_valid | input | 1 | Segment image offered |
| pat_ready | output | 1 | Image accepted this cycle (frame boundary) |
| pat_data | input | SEG_N*COM_N | Segment image; bit index is common*SEG_N + segment |
| seg_out | output | SEG_N | Segment line levels |
| com_out | output | COM_N | Common line levels when driven |
| com_oe | output | COM_N | Common output enables (0 = released to mid level) |
| bias_en | output | 1 | Enables the external half-supply divider |
| frame_start | output | 1 | Pulse at the start of each frame |

## Verification
The hardest case to reach from the ports is a change that lands on the frame boundary. This covers a new image, contrast, length or mode arriving in the single ready cycle, and an enable drop or restart in the middle of a period. The bench shortens the prescaler and the periods so that a frame takes only tens of cycles. It then holds random settings for random lengths, so that the changes fall before, on and after boundaries. Directed cases cover a contrast of zero, a contrast equal to and above the period length, and period lengths of 0 and 1.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;
  // Rule applied on all lines during the dead part of a control period
  typedef enum logic {
    DEAD_LOW   = 1'b0,  // everything grounded: lowers RMS
    DEAD_BOOST = 1'b1   // commons hold, segments opposite: raises RMS
  } dead_mode_e;
endpackage

// File: rtl/lcdq_prescale.sv
module lcdq_prescale #(
  parameter int unsigned DIV = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] pre;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre <= '0;
        else if (!run)   pre <= '0;
        else if (tick)   pre <= '0;
        else             pre <= pre + 1'b1;
      end

      assign tick = run && (pre == PW'(DIV - 1));

      // R2: steps are at least two clocks apart when dividing
      a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/lcdq_timer.sv
module lcdq_timer #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned PER_N = 8,
  localparam int unsigned PI_W = $clog2(PER_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] plen_q,
  input  logic [CNT_W-1:0] cont_q,
  output logic             run,
  output logic [PI_W-1:0]  per_idx,
  output logic [CNT_W-1:0] tcnt,
  output logic             active,
  output logic             load,
  output logic             frame_start
);
  localparam logic [PI_W-1:0] LAST = PI_W'(PER_N - 1);

  logic last_step;
  assign last_step = tick && (tcnt == plen_q - 1'b1);
  assign load      = en && (!run || (last_step && per_idx == LAST));
  assign active    = (cont_q < plen_q) && (tcnt < (plen_q - cont_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; per_idx <= '0; tcnt <= '0; frame_start <= 1'b0;
    end else if (!en) begin
      run <= 1'b0; per_idx <= '0; tcnt <= '0; frame_start <= 1'b0;
    end else begin
      frame_start <= load;
      if (!run) begin
        run <= 1'b1; per_idx <= '0; tcnt <= '0;
      end else if (tick) begin
        if (last_step) begin
          tcnt    <= '0;
          per_idx <= (per_idx == LAST) ? '0 : per_idx + 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  // R2: step counter never reaches the period length
  a_r2_tcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> tcnt < plen_q);
  // R2: a step that is not the last advances by one
  a_r2_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    en && run && tick && !last_step |=> tcnt == $past(tcnt) + 1'b1);
  // R1: a low enable stops the sequencer at the next edge
  a_r1_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !run);
  // R10: the frame pulse marks the origin of the frame
  a_r10_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> run && per_idx == '0 && tcnt == '0);
endmodule

// File: rtl/lcdq_drive.sv
module lcdq_drive
  import lcdq_pkg::*;
#(
  parameter int unsigned SEG_N = 32,
  parameter int unsigned COM_N = 4,
  localparam int unsigned PI_W = $clog2(2 * COM_N),
  localparam int unsigned PAT_W = SEG_N * COM_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             active,
  input  dead_mode_e       mode_q,
  input  logic [PI_W-1:0]  per_idx,
  input  logic [PAT_W-1:0] pat_q,
  output logic [SEG_N-1:0] seg_out,
  output logic [COM_N-1:0] com_out,
  output logic [COM_N-1:0] com_oe,
  output logic             bias_en
);
  logic [PI_W-2:0]  phase;
  logic             pol;
  logic [COM_N-1:0] sel;
  logic [SEG_N-1:0] row;

  assign phase = per_idx[PI_W-1:1];
  assign pol   = per_idx[0];
  assign row   = pat_q[phase * SEG_N +: SEG_N];

  generate
    for (genvar c = 0; c < COM_N; c++) begin : g_sel
      assign sel[c] = (phase == (PI_W-1)'(c));
    end
  endgenerate

  always_comb begin
    seg_out = '0;
    com_out = '0;
    com_oe  = '1;
    bias_en = run;
    if (run) begin
      if (active) begin
        seg_out = row ^ {SEG_N{pol}};
        com_oe  = sel;
        com_out = sel & {COM_N{pol}};
      end else if (mode_q == DEAD_BOOST) begin
        seg_out = {SEG_N{~pol}};
        com_out = {COM_N{pol}};
      end
    end
  end

  // R3: during the active part exactly one common is driven
  a_r3_one_common: assert property (@(posedge clk) disable iff (!rst_n)
    run && active |-> $countones(com_oe) == 1);
  // R6: every dead part drives all commons
  a_r6_dead_driven: assert property (@(posedge clk) disable iff (!rst_n)
    run && !active |-> &com_oe);
  // R1: with the bias off, nothing is high
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_en |-> seg_out == '0 && com_out == '0);
endmodule

// File: rtl/lcdq_seq.sv
module lcdq_seq
  import lcdq_pkg::*;
#(
  parameter int unsigned SEG_N = 32,
  parameter int unsigned COM_N = 4,
  parameter int unsigned CNT_W = 13,
  parameter int unsigned DIV   = 56,
  localparam int unsigned PAT_W = SEG_N * COM_N,
  localparam int unsigned PER_N = 2 * COM_N,
  localparam int unsigned PI_W  = $clog2(PER_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode,
  input  logic [CNT_W-1:0] period_len,
  input  logic [CNT_W-1:0] contrast,
  input  logic             pat_valid,
  output logic             pat_ready,
  input  logic [PAT_W-1:0] pat_data,
  output logic [SEG_N-1:0] seg_out,
  output logic [COM_N-1:0] com_out,
  output logic [COM_N-1:0] com_oe,
  output logic             bias_en,
  output logic             frame_start
);
  logic [PAT_W-1:0] pat_q;
  logic [CNT_W-1:0] cont_q, plen_q, tcnt;
  dead_mode_e       mode_q;
  logic             run, tick, active, load;
  logic [PI_W-1:0]  per_idx;

  // Frame-boundary shadow of image and settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= '0;
      cont_q <= '0;
      plen_q <= CNT_W'(1);
      mode_q <= DEAD_LOW;
    end else if (load) begin
      cont_q <= contrast;
      plen_q <= (period_len == '0) ? CNT_W'(1) : period_len;
      mode_q <= dead_mode_e'(mode);
      if (pat_valid) pat_q <= pat_data;
    end
  end

  assign pat_ready = load;

  lcdq_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  lcdq_timer #(.CNT_W(CNT_W), .PER_N(PER_N)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .plen_q(plen_q), .cont_q(cont_q),
    .run(run), .per_idx(per_idx), .tcnt(tcnt), .active(active),
    .load(load), .frame_start(frame_start)
  );

  lcdq_drive #(.SEG_N(SEG_N), .COM_N(COM_N)) u_drv (
    .clk(clk), .rst_n(rst_n), .run(run), .active(active), .mode_q(mode_q),
    .per_idx(per_idx), .pat_q(pat_q),
    .seg_out(seg_out), .com_out(com_out), .com_oe(com_oe), .bias_en(bias_en)
  );

  // R8: the image only changes in a boundary cycle
  a_r8_pat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pat_q));
  // R9: settings only change in a boundary cycle
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({cont_q, plen_q, mode_q}));
endmodule

// File: tb/lcdq_seq_test.sv
module lcdq_seq_test;
  localparam int DIV = 2;
  localparam int CW  = 13;

  logic clk = 1'b0;
  logic rst_n, en, mode, pat_valid;
  logic [CW-1:0] period_len, contrast;
  logic [127:0] pat_data;
  logic pat_ready, bias_en, frame_start;
  logic [31:0] seg_out;
  logic [3:0]  com_out, com_oe;

  always #4 clk = ~clk;  // 125 MHz

  lcdq_seq #(.SEG_N(32), .COM_N(4), .CNT_W(CW), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .period_len(period_len), .contrast(contrast),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_data(pat_data),
    .seg_out(seg_out), .com_out(com_out), .com_oe(com_oe),
    .bias_en(bias_en), .frame_start(frame_start)
  );

  int checks = 0, errors = 0;
  // reference state
  bit m_run = 0;
  int n = 0, m_plen = 1, m_cont = 0, m_mode = 0;
  bit m_zero_len = 0;
  logic [127:0] m_pat = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int flen();
    return 8 * DIV * m_plen;
  endfunction

  function automatic bit exp_ready();
    return en && (!m_run || n == flen() - 1);
  endfunction

  task automatic compare();
    logic [63:0] e;
    string req;
    int ts, k, ph, pol;
    bit act;
    e = '0;
    if (!m_run) begin
      e = {23'd0, 1'b0, 4'hF, 4'h0, 32'h0};
      req = "R1 disabled";
    end else begin
      ts  = (n / DIV) % m_plen;
      k   = n / (DIV * m_plen);
      ph  = k / 2;
      pol = k % 2;
      act = (m_cont < m_plen) && (ts < m_plen - m_cont);
      if (act) begin
        e[40]    = 1'b1;
        e[39:36] = 4'(1 << ph);
        e[35:32] = pol ? 4'(1 << ph) : 4'h0;
        e[31:0]  = m_pat[ph*32 +: 32] ^ {32{pol[0]}};
        req = pol ? "R4 active high (R2 R5 R9)" : "R3 active low (R2 R5 R9)";
      end else begin
        e[40]    = 1'b1;
        e[39:36] = 4'hF;
        if (m_mode == 1) begin
          e[35:32] = pol ? 4'hF : 4'h0;
          e[31:0]  = pol ? 32'h0 : 32'hFFFF_FFFF;
          req = "R7 dead boost (R2 R5)";
        end else begin
          req = "R6 dead low (R2 R5)";
        end
      end
      if (m_zero_len) req = {req, " R11"};
    end
    chk(req, {23'd0, bias_en, com_oe, com_out, seg_out}, e);
    chk("R10 frame_start", 64'(frame_start), 64'(m_run && n == 0));
    chk("R8 pat_ready", 64'(pat_ready), 64'(exp_ready()));
  endtask

  task automatic step();
    bit s_rst, s_en, s_valid, s_rdy;
    logic [127:0] s_data;
    int s_plen, s_cont, s_mode;
    s_rst = rst_n; s_en = en; s_valid = pat_valid; s_data = pat_data;
    s_plen = int'(period_len); s_cont = int'(contrast); s_mode = int'(mode);
    s_rdy = exp_ready();
    @(posedge clk); #2;
    if (!s_rst || !s_en) m_run = 0;
    else begin
      bit ld;
      ld = 0;
      if (!m_run) begin m_run = 1; n = 0; ld = 1; end
      else begin
        n++;
        if (n == flen()) begin n = 0; ld = 1; end
      end
      if (ld) begin  // R9: sampled only here
        m_cont = s_cont; m_mode = s_mode;
        m_zero_len = (s_plen == 0);
        m_plen = (s_plen == 0) ? 1 : s_plen;
        if (s_valid) m_pat = s_data;
      end
    end
    if (s_rst && s_valid && s_rdy) pat_valid = 1'b0;
    compare();
  endtask

  task automatic run_cycles(int c);
    for (int i = 0; i < c; i++) step();
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; en = 0; mode = 0; pat_valid = 0; pat_data = '0;
    period_len = 13'd6; contrast = '0;
    run_cycles(4);                  // R1 during reset
    rst_n = 1;
    run_cycles(3);                  // R1 enable low
    // full active, lowering mode
    en = 1; pat_data = rnd128(); pat_valid = 1;
    run_cycles(300);
    // raising mode with short dead part
    mode = 1; contrast = 13'd2; pat_data = rnd128(); pat_valid = 1;
    run_cycles(200);
    // R5: contrast equal to and above the period length
    contrast = 13'd6; run_cycles(200);
    contrast = 13'd9; run_cycles(120);
    // R9: length and mode change in mid frame
    mode = 0; contrast = 13'd3; run_cycles(37);
    period_len = 13'd4; pat_data = rnd128(); pat_valid = 1;
    run_cycles(250);
    // R11: zero length, then length 1
    period_len = '0; contrast = '0; mode = 1; run_cycles(80);
    period_len = 13'd1; contrast = 13'd1; run_cycles(60);
    // enable drop in mid frame and restart
    period_len = 13'd5; contrast = 13'd1; run_cycles(53);
    en = 0; run_cycles(3);
    en = 1; run_cycles(120);
    // constrained random
    for (int it = 0; it < 60; it++) begin
      int pl;
      pl = $urandom_range(1, 12);
      period_len = CW'(pl);
      contrast   = CW'($urandom_range(0, pl + 2));
      mode       = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) begin
        pat_data = rnd128(); pat_valid = 1;
      end
      if ($urandom_range(0, 5) == 0) begin
        en = 0; run_cycles($urandom_range(1, 4)); en = 1;
      end
      run_cycles($urandom_range(10, 260));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule